// File: doc/BRIEF.md
# Oversampled Camera Bus Capture

This block takes an 8-bit parallel camera bus, a small group of sync lines, and the slow pixel clock that the camera sends with them. It brings all of them into the fast core clock domain. The camera clock is never used to clock any flop. A two-flop synchroniser brings the camera clock, data and sync lines into the core domain together. The block keeps the previous sampled level of the camera clock and detects the selected edge, falling or rising, by comparing the two. After a programmable delay of whole core cycles, it raises a registered ready strobe. The data and sync values present at that moment are latched together into holding registers.

Each captured pixel also drives a horizontal pixel counter. When the captured sync value equals a programmed match pattern, the counter is cleared. Otherwise the counter steps, and when it would reach the programmed line length it wraps to zero and fires a one-cycle line request. Downstream logic uses that request to ask the sensor for its next line.

The output is a valid-only stream: `pix_valid` marks each new word for one core cycle, and there is no ready input. The camera cannot be stalled, so the consumer must take every word in the cycle it is marked. The captured word stays on `pix_data`/`pix_sync` until the next one arrives. Correct capture needs the camera data to stay stable for more than two core cycles, plus the programmed delay, after the selected edge.

Top module: `cam_capture_core`

## Requirements
- R1: After reset, `pix_valid`, `line_req`, `pix_count`, `pix_data` and `pix_sync` are all zero.
- R2: With `cfg_edge_rise` = 0, exactly one `pix_valid` pulse follows each high-to-low transition of `cam_clk_in`, and none follows a low-to-high transition.
- R3: With `cfg_edge_rise` = 1, exactly one `pix_valid` pulse follows each low-to-high transition of `cam_clk_in`, and none follows a high-to-low transition.
- R4: Call the first core rising edge at which a new `cam_clk_in` level is present edge 0. `pix_valid` is then high during the cycle after core edge 3 + `cfg_delay`.
- R5: When `pix_valid` is high, `pix_data` and `pix_sync` show the bus and sync values held stable across the selected edge and the following `cfg_delay` + 2 core cycles. Both hold that value until the next pulse.
- R6: `pix_valid` is never high for two consecutive core cycles.
- R7: When `pix_valid` rises, `pix_count` is 0 if the captured sync equals `cfg_sync_match`. Otherwise it is the previous count plus one.
- R8: When a non-matching pixel would bring the count to `cfg_line_len`, the count becomes 0 and `line_req` is high for that single cycle, together with `pix_valid`. `line_req` is high at no other time.
- R9: While `cam_clk_in` does not toggle, no `pix_valid` or `line_req` occurs, whatever the data and sync lines do. `pix_count` and `pix_data` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (all logic) |
| rst_n | input | 1 | Active-low synchronous reset |
| cam_clk_in | input | 1 | Camera pixel clock, sampled as data |
| cam_data_in | input | DW (8) | Camera parallel data bus |
| cam_sync_in | input | SW (2) | Camera sync lines |
| cfg_edge_rise | input | 1 | 0 = capture on falling edge, 1 = on rising edge |
| cfg_delay | input | DLY_W (4) | Extra core cycles between edge detection and capture |
| cfg_sync_match | input | SW (2) | Sync value that clears the pixel counter |
| cfg_line_len | input | CNT_W (16) | Pixel count at which a line request fires |
| pix_valid | output | 1 | One-cycle marker of a newly captured word |
| pix_data | output | DW (8) | Captured data word |
| pix_sync | output | SW (2) | Captured sync value |
| pix_count | output | CNT_W (16) | Horizontal pixel counter |
| line_req | output | 1 | One-cycle request for the next sensor line |

## Verification
The bench uses the default widths (8-bit data, 2 sync lines, 4-bit delay, 16-bit counter) with a line length of 5 and a match pattern of 01. It sweeps both capture edges and every delay from 0 to 11. Each delay setting drives a camera clock with 16-core-cycle phases, so the pixel latency is measured exactly for each setting.

The short line length makes the counter wrap and raise line requests many times. A match pattern on every seventh pixel clears the counter at varying offsets within the line. A long idle stretch with the camera clock stopped and the data and sync lines still toggling exercises the missing-clock case.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage1[i] <= 1'b0;
          stage2[i] <= 1'b0;
        end else begin
          stage1[i] <= d_in[i];
          stage2[i] <= stage1[i];
        end
      end
    end
  endgenerate

  assign d_out = stage2;
endmodule

// File: rtl/cap_strobe.sv
module cap_strobe
  import cap_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cam_lvl,
  input  logic             edge_rise,
  input  logic [DLY_W-1:0] delay,
  output logic             rdy
);
  edge_sel_e        sel;
  logic             prev_lvl;
  logic             edge_seen;
  logic             armed;
  logic [DLY_W-1:0] wait_cnt;
  logic             fire;

  assign sel = edge_sel_e'(edge_rise);

  // previous camera-clock level, one core cycle old
  always_ff @(posedge clk) begin
    if (!rst_n) prev_lvl <= 1'b0;
    else        prev_lvl <= cam_lvl;
  end

  always_comb begin
    if (sel == EDGE_RISE) edge_seen = cam_lvl & ~prev_lvl;
    else                  edge_seen = ~cam_lvl & prev_lvl;
  end

  assign fire = (edge_seen && (delay == '0)) ||
                (armed && (wait_cnt == DLY_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy      <= 1'b0;
      armed    <= 1'b0;
      wait_cnt <= '0;
    end else begin
      rdy <= fire;
      if (edge_seen && (delay != '0)) begin
        wait_cnt <= delay;
        armed    <= 1'b1;
      end else if (armed) begin
        wait_cnt <= wait_cnt - 1'b1;
        if (wait_cnt == DLY_W'(1)) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cap_line_counter.sv
module cap_line_counter #(
  parameter int CNT_W = 16,
  parameter int SW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdy,
  input  logic [SW-1:0]    sync_now,
  input  logic [SW-1:0]    sync_match,
  input  logic [CNT_W-1:0] line_len,
  output logic [CNT_W-1:0] count,
  output logic             line_req
);
  logic [CNT_W-1:0] nxt;

  assign nxt = count + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      line_req <= 1'b0;
    end else if (rdy) begin
      if (sync_now == sync_match) begin
        count    <= '0;
        line_req <= 1'b0;
      end else if (nxt == line_len) begin
        count    <= '0;
        line_req <= 1'b1;
      end else begin
        count    <= nxt;
        line_req <= 1'b0;
      end
    end else begin
      line_req <= 1'b0;
    end
  end
endmodule

// File: rtl/cam_capture_core.sv
module cam_capture_core #(
  parameter int DW    = 8,
  parameter int SW    = 2,
  parameter int DLY_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cam_clk_in,
  input  logic [DW-1:0]    cam_data_in,
  input  logic [SW-1:0]    cam_sync_in,
  input  logic             cfg_edge_rise,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [SW-1:0]    cfg_sync_match,
  input  logic [CNT_W-1:0] cfg_line_len,
  output logic             pix_valid,
  output logic [DW-1:0]    pix_data,
  output logic [SW-1:0]    pix_sync,
  output logic [CNT_W-1:0] pix_count,
  output logic             line_req
);
  localparam int BUS_W = 1 + SW + DW;

  logic [BUS_W-1:0] raw_bus;
  logic [BUS_W-1:0] sync_bus;
  logic             cam_lvl;
  logic [SW-1:0]    sync_s;
  logic [DW-1:0]    data_s;
  logic             rdy;

  assign raw_bus = {cam_clk_in, cam_sync_in, cam_data_in};

  cap_sync #(.W(BUS_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_bus),
    .d_out (sync_bus)
  );

  assign cam_lvl = sync_bus[BUS_W-1];
  assign sync_s  = sync_bus[DW +: SW];
  assign data_s  = sync_bus[DW-1:0];

  cap_strobe #(.DLY_W(DLY_W)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .cam_lvl   (cam_lvl),
    .edge_rise (cfg_edge_rise),
    .delay     (cfg_delay),
    .rdy       (rdy)
  );

  // holding registers: data and sync latched together
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_sync  <= '0;
    end else begin
      pix_valid <= rdy;
      if (rdy) begin
        pix_data <= data_s;
        pix_sync <= sync_s;
      end
    end
  end

  cap_line_counter #(.CNT_W(CNT_W), .SW(SW)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdy        (rdy),
    .sync_now   (sync_s),
    .sync_match (cfg_sync_match),
    .line_len   (cfg_line_len),
    .count      (pix_count),
    .line_req   (line_req)
  );
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int DW    = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic [DW-1:0]    pix_data,
  input logic [CNT_W-1:0] pix_count,
  input logic             line_req
);
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid); // R6

  AST_LINE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    line_req |-> pix_valid); // R8

  AST_LINE_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    line_req |-> (pix_count == '0)); // R8

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> $stable(pix_count)); // R9

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> $stable(pix_data)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_req && (pix_count != '0)) |->
      (pix_count == CNT_W'($past(pix_count) + 1'b1))); // R7
endmodule

bind cam_capture_core cap_checker #(.DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_valid (pix_valid),
  .pix_data  (pix_data),
  .pix_count (pix_count),
  .line_req  (line_req)
);

// File: tb/sim_cam_capture_core.sv
module sim_cam_capture_core;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int SW         = 2;
  localparam int DLY_W      = 4;
  localparam int CNT_W      = 16;
  localparam int LINE_LEN   = 5;
  localparam int PHASE      = 16;
  localparam logic [SW-1:0] MATCH = 2'b01;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cam_clk = 1'b0;
  logic [DW-1:0]    cam_data = '0;
  logic [SW-1:0]    cam_sync = '0;
  logic             cfg_rise = 1'b0;
  logic [DLY_W-1:0] cfg_delay = '0;
  logic             pix_valid;
  logic [DW-1:0]    pix_data;
  logic [SW-1:0]    pix_sync;
  logic [CNT_W-1:0] pix_count;
  logic             line_req;

  cam_capture_core #(.DW(DW), .SW(SW), .DLY_W(DLY_W), .CNT_W(CNT_W)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .cam_clk_in     (cam_clk),
    .cam_data_in    (cam_data),
    .cam_sync_in    (cam_sync),
    .cfg_edge_rise  (cfg_rise),
    .cfg_delay      (cfg_delay),
    .cfg_sync_match (MATCH),
    .cfg_line_len   (CNT_W'(LINE_LEN)),
    .pix_valid      (pix_valid),
    .pix_data       (pix_data),
    .pix_sync       (pix_sync),
    .pix_count      (pix_count),
    .line_req       (line_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0;
  int nerr = 0;
  int t_edge = 0;
  int strobes = 0;
  int lreqs = 0;
  int last_lat = 0;
  int last_data = 0;
  int last_sync = 0;
  int last_count = 0;
  int last_lr = 0;
  int run = 0;
  int max_run = 0;
  int exp_cnt = 0;
  int exp_lr = 0;
  int g = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n && pix_valid) begin
      strobes++;
      last_lat   = cyc - t_edge;
      last_data  = int'(pix_data);
      last_sync  = int'(pix_sync);
      last_count = int'(pix_count);
      last_lr    = int'(line_req);
      run++;
      if (run > max_run) max_run = run;
    end else begin
      run = 0;
    end
    if (rst_n && line_req) lreqs++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] sync_pat(input int idx);
    if (idx % 7 == 6)      return MATCH;
    else if (idx % 3 == 0) return 2'b00;
    else if (idx % 3 == 1) return 2'b10;
    else                   return 2'b11;
  endfunction

  // one camera period: rising edge, high phase, falling edge, long low phase
  task automatic do_pixel(input logic [DW-1:0] d, input logic [SW-1:0] s);
    int s0;
    int l0;
    s0 = strobes;
    l0 = lreqs;
    @(negedge clk);
    cam_clk  = 1'b1;
    cam_data = d;
    cam_sync = s;
    if (cfg_rise) t_edge = cyc;
    repeat (PHASE) @(negedge clk);
    cam_clk = 1'b0;
    if (!cfg_rise) t_edge = cyc;
    repeat (2*PHASE) @(negedge clk);
    if (s == MATCH) begin
      exp_cnt = 0; exp_lr = 0;
    end else if (exp_cnt + 1 == LINE_LEN) begin
      exp_cnt = 0; exp_lr = 1;
    end else begin
      exp_cnt++; exp_lr = 0;
    end
    if (cfg_rise) chk("R3 one strobe per rising edge", strobes - s0, 1);
    else          chk("R2 one strobe per falling edge", strobes - s0, 1);
    chk("R4 latency", last_lat, 4 + int'(cfg_delay));
    chk("R5 captured data", last_data, int'(d));
    chk("R5 captured sync", last_sync, int'(s));
    chk("R7 pixel count", last_count, exp_cnt);
    chk("R8 line_req with strobe", last_lr, exp_lr);
    chk("R8 line_req pulses", lreqs - l0, exp_lr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int s0;
    int l0;
    int d_hold;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pix_valid", int'(pix_valid), 0);
    chk("R1 reset line_req", int'(line_req), 0);
    chk("R1 reset pix_count", int'(pix_count), 0);
    chk("R1 reset pix_data", int'(pix_data), 0);
    chk("R1 reset pix_sync", int'(pix_sync), 0);

    for (int r = 0; r < 2; r++) begin
      for (int dl = 0; dl < 12; dl++) begin
        @(negedge clk);
        cfg_rise  = r[0];
        cfg_delay = DLY_W'(dl);
        for (int j = 0; j < 6; j++) begin
          g++;
          do_pixel(DW'(g * 29 + 7), sync_pat(g));
        end
      end
    end

    // camera clock stopped, bus keeps moving (R9)
    s0 = strobes;
    l0 = lreqs;
    d_hold = int'(pix_data);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      cam_data = cam_data + 8'd3;
      cam_sync = cam_sync ^ SW'(k);
    end
    chk("R9 no strobe without clock", strobes - s0, 0);
    chk("R9 no line_req without clock", lreqs - l0, 0);
    chk("R9 count unchanged", int'(pix_count), exp_cnt);
    chk("R9 data unchanged", int'(pix_data), d_hold);
    chk("R6 single-cycle valid", max_run, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule